// File: doc/BRIEF.md
# Offset-Stream Multiply-Accumulate Kernel

This block is a fully pipelined streaming kernel. One element from each of four input streams enters every clock cycle: a history stream `hist_in` and three coefficient streams `mul_x`, `mul_y`, `mul_z`. One result leaves every cycle. With h, x, y and z for those streams, result i is h[i-10]*x[i] + h[i-5]*y[i] + h[i+15]*z[i]. Two of the h terms look backwards in the stream, and one looks 15 elements ahead. Multipliers are modelled as 5-cycle pipelines and adders as 10-cycle pipelines. The look-ahead is built by holding back the three coefficient streams by 15 elements. A single chain of 25 h registers is tapped at two depths, and the live input gives the third operand. The third product waits 10 cycles so that it meets the first partial sum.

The stream is indexed by cycle. A cycle with `in_valid` low is a zero element, whatever sits on the data pins. Therefore any term whose h index lies before the start of a burst, after its end, or in a gap reads as zero. A small controller has three states. ST_IDLE is the state after reset. It moves to ST_ACTIVE on any valid input. ST_ACTIVE moves to ST_DRAIN on the first cycle with no valid input. ST_DRAIN returns to ST_ACTIVE on a valid input, and moves to ST_IDLE once 39 further quiet cycles have passed, by which time every register holds zero. In ST_IDLE the pipeline registers are frozen unless a valid input arrives. Freezing them has no effect on results.

Top module: `stream_ofs_mac`

## Requirements
- R1: `acc_out` equals h[i-10]*x[i] + h[i-5]*y[i] + h[i+15]*z[i] for element i. All operands are signed two's complement DW-bit values, and the result is a signed 2*DW+2-bit value. The result appears exactly 40 cycles after the cycle in which element i was presented.
- R2: `out_valid` is high in cycle n+40 exactly when `in_valid` was high in cycle n.
- R3: An h index before the first element of the stream contributes zero, so the first ten results use only the terms whose index exists.
- R4: At the end of a burst, the h index up to 15 elements beyond the last valid element contributes zero.
- R5: Whenever `out_valid` is low, `acc_out` is zero.
- R6: With every operand at the most negative or most positive DW-bit value, the result is exact, with no wrap.
- R7: During and directly after reset, `out_valid` is 0 and `acc_out` is 0.
- R8: Data pins sampled while `in_valid` is low have no effect on any result, including results whose offset terms fall in such cycles. This holds across gaps long enough for the controller to reach ST_IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Current cycle carries a stream element |
| hist_in | input | DW | Stream read at offsets -10, -5 and +15 |
| mul_x | input | DW | Coefficient paired with the -10 history term |
| mul_y | input | DW | Coefficient paired with the -5 history term |
| mul_z | input | DW | Coefficient paired with the +15 history term |
| out_valid | output | 1 | `acc_out` holds a result for a valid element |
| acc_out | output | 2*DW+2 | Signed sum of the three products |

## Verification
If a lane has the wrong delay depth, or a history tap sits in the wrong place, every valid result built from random data miscompares. This shows 40 cycles after the first valid element, and the first ten elements of a burst, whose look-back terms should be zero, show it at once. If the 10-cycle balance delay is wrong, or a product is truncated, the result breaks on the extreme-value segment. If the drain count is too short, the last result of a burst is frozen and `out_valid` stays high. If masking is missing, nonzero `acc_out` appears in cycles whose `out_valid` is low, beginning 40 cycles after the first garbage input.

// File: rtl/stream_ofs_pkg.sv
`timescale 1ns/1ps
package stream_ofs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_DRAIN  = 2'd2
    } ctrl_state_e;
endpackage

// File: rtl/ofs_pipe.sv
`timescale 1ns/1ps
// Enable-gated delay line; dout is din from DEPTH enabled edges earlier.
module ofs_pipe #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    generate
        if (DEPTH == 0) begin : g_wire
            assign dout = din;
        end else begin : g_regs
            logic [WIDTH-1:0] stg [DEPTH];

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
                end else if (en) begin
                    stg[0] <= din;
                    for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
                end
            end

            assign dout = stg[DEPTH-1];

            // R8: a frozen pipeline never changes what it presents
            p_hold_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
                !en |=> $stable(dout));
        end
    endgenerate
endmodule

// File: rtl/ofs_mul.sv
`timescale 1ns/1ps
// Signed multiplier modelled as a LAT-stage pipeline.
module ofs_mul #(
    parameter int W   = 16,
    parameter int LAT = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] p
);
    logic signed [2*W-1:0] prod;
    assign prod = $signed(a) * $signed(b);

    ofs_pipe #(.WIDTH(2*W), .DEPTH(LAT)) u_lat (
        .clk(clk), .rst_n(rst_n), .en(en), .din(prod), .dout(p)
    );
endmodule

// File: rtl/ofs_add.sv
`timescale 1ns/1ps
// Signed adder with sign-extended operands, modelled as a LAT-stage pipeline.
module ofs_add #(
    parameter int AW  = 32,
    parameter int BW  = 32,
    parameter int OW  = 33,
    parameter int LAT = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [AW-1:0] a,
    input  logic [BW-1:0] b,
    output logic [OW-1:0] s
);
    logic [OW-1:0] ax, bx, sum;
    assign ax  = {{(OW-AW){a[AW-1]}}, a};
    assign bx  = {{(OW-BW){b[BW-1]}}, b};
    assign sum = ax + bx;

    ofs_pipe #(.WIDTH(OW), .DEPTH(LAT)) u_lat (
        .clk(clk), .rst_n(rst_n), .en(en), .din(sum), .dout(s)
    );
endmodule

// File: rtl/ofs_ctrl.sv
`timescale 1ns/1ps
// Warm-up / drain controller: keeps the pipeline clocked until it is empty.
module ofs_ctrl
    import stream_ofs_pkg::*;
#(
    parameter int LAT = 40
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    output logic        en,
    output ctrl_state_e state
);
    localparam int CNT_W = $clog2(LAT + 1);
    localparam logic [CNT_W-1:0] LAST_Q = CNT_W'(LAT - 1);

    ctrl_state_e      nxt;
    logic [CNT_W-1:0] quiet_cnt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (in_valid) nxt = ST_ACTIVE;
            ST_ACTIVE: if (!in_valid) nxt = ST_DRAIN;
            ST_DRAIN: begin
                if (in_valid)                nxt = ST_ACTIVE;
                else if (quiet_cnt == LAST_Q) nxt = ST_IDLE;
            end
            default:   nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            quiet_cnt <= '0;
        end else begin
            state <= nxt;
            if (nxt == ST_DRAIN)
                quiet_cnt <= (state == ST_DRAIN) ? quiet_cnt + 1'b1 : CNT_W'(1);
            else
                quiet_cnt <= '0;
        end
    end

    always_comb begin
        en = (state != ST_IDLE) || in_valid;
    end

    // R2: drain count stays inside the window that empties the pipeline
    p_drain_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAIN) |-> (quiet_cnt >= CNT_W'(1) && quiet_cnt <= LAST_Q));
endmodule

// File: rtl/stream_ofs_mac.sv
`timescale 1ns/1ps
module stream_ofs_mac
    import stream_ofs_pkg::*;
#(
    parameter int DW       = 16,
    parameter int LAG_FAR  = 10,
    parameter int LAG_NEAR = 5,
    parameter int LEAD     = 15,
    parameter int MUL_LAT  = 5,
    parameter int ADD_LAT  = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [DW-1:0]   hist_in,
    input  logic [DW-1:0]   mul_x,
    input  logic [DW-1:0]   mul_y,
    input  logic [DW-1:0]   mul_z,
    output logic            out_valid,
    output logic [2*DW+1:0] acc_out
);
    localparam int PW         = 2 * DW;
    localparam int SW1        = PW + 1;
    localparam int CW         = PW + 2;
    localparam int NEAR_DEPTH = LEAD + LAG_NEAR;
    localparam int FAR_EXTRA  = LAG_FAR - LAG_NEAR;
    localparam int TOTAL_LAT  = LEAD + MUL_LAT + 2 * ADD_LAT;
    localparam int N_LANE     = 3;

    ctrl_state_e fsm_state;
    logic        en;

    ofs_ctrl #(.LAT(TOTAL_LAT)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .en(en), .state(fsm_state)
    );

    // Invalid cycles are zero elements.
    logic [DW-1:0] h_m, x_m, y_m, z_m;
    assign h_m = in_valid ? hist_in : '0;
    assign x_m = in_valid ? mul_x   : '0;
    assign y_m = in_valid ? mul_y   : '0;
    assign z_m = in_valid ? mul_z   : '0;

    // Shared history chain: near tap after NEAR_DEPTH, far tap FAR_EXTRA later.
    logic [DW-1:0] h_near, h_far;
    ofs_pipe #(.WIDTH(DW), .DEPTH(NEAR_DEPTH)) u_hist_near (
        .clk(clk), .rst_n(rst_n), .en(en), .din(h_m), .dout(h_near)
    );
    ofs_pipe #(.WIDTH(DW), .DEPTH(FAR_EXTRA)) u_hist_far (
        .clk(clk), .rst_n(rst_n), .en(en), .din(h_near), .dout(h_far)
    );

    logic [DW-1:0] opa     [N_LANE];
    logic [DW-1:0] opb_raw [N_LANE];
    logic [DW-1:0] opb     [N_LANE];
    logic [PW-1:0] prod    [N_LANE];

    assign opa[0] = h_far;   assign opb_raw[0] = x_m;
    assign opa[1] = h_near;  assign opb_raw[1] = y_m;
    assign opa[2] = h_m;     assign opb_raw[2] = z_m;

    generate
        for (genvar k = 0; k < N_LANE; k++) begin : g_lane
            ofs_pipe #(.WIDTH(DW), .DEPTH(LEAD)) u_lead (
                .clk(clk), .rst_n(rst_n), .en(en), .din(opb_raw[k]), .dout(opb[k])
            );
            ofs_mul #(.W(DW), .LAT(MUL_LAT)) u_mul (
                .clk(clk), .rst_n(rst_n), .en(en), .a(opa[k]), .b(opb[k]), .p(prod[k])
            );
        end
    endgenerate

    logic [SW1-1:0] sum1;
    logic [PW-1:0]  prod2_bal;

    ofs_add #(.AW(PW), .BW(PW), .OW(SW1), .LAT(ADD_LAT)) u_add1 (
        .clk(clk), .rst_n(rst_n), .en(en), .a(prod[0]), .b(prod[1]), .s(sum1)
    );
    ofs_pipe #(.WIDTH(PW), .DEPTH(ADD_LAT)) u_balance (
        .clk(clk), .rst_n(rst_n), .en(en), .din(prod[2]), .dout(prod2_bal)
    );
    ofs_add #(.AW(SW1), .BW(PW), .OW(CW), .LAT(ADD_LAT)) u_add2 (
        .clk(clk), .rst_n(rst_n), .en(en), .a(sum1), .b(prod2_bal), .s(acc_out)
    );

    ofs_pipe #(.WIDTH(1), .DEPTH(TOTAL_LAT)) u_vld (
        .clk(clk), .rst_n(rst_n), .en(en), .din(in_valid), .dout(out_valid)
    );

    // R5: datapath and valid path agree on empty slots
    p_quiet_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (acc_out == '0));

    // R7: an idle controller means the pipeline holds no valid element
    p_idle_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_IDLE) |-> !out_valid);
endmodule

// File: tb/stream_ofs_mac_tb_top.sv
`timescale 1ns/1ps
module stream_ofs_mac_tb_top;
    localparam int DW  = 16;
    localparam int LAT = 40;
    localparam int NEL = 640;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [DW-1:0]   hist_in = '0, mul_x = '0, mul_y = '0, mul_z = '0;
    logic            out_valid;
    logic [2*DW+1:0] acc_out;

    int n_chk = 0;
    int n_bad = 0;

    logic          vld [NEL];
    logic [DW-1:0] dh [NEL], dx [NEL], dy [NEL], dz [NEL];

    always #2.5 clk = ~clk;

    stream_ofs_mac dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .hist_in(hist_in), .mul_x(mul_x), .mul_y(mul_y), .mul_z(mul_z),
        .out_valid(out_valid), .acc_out(acc_out)
    );

    function automatic bit live(int idx);
        if (idx < 0 || idx >= NEL) return 1'b0;
        return vld[idx];
    endfunction

    function automatic longint val(int idx, int sel);
        if (!live(idx)) return 0;
        case (sel)
            0:       return longint'($signed(dh[idx]));
            1:       return longint'($signed(dx[idx]));
            2:       return longint'($signed(dy[idx]));
            default: return longint'($signed(dz[idx]));
        endcase
    endfunction

    function automatic longint model(int j);
        return val(j-10, 0) * val(j, 1) + val(j-5, 0) * val(j, 2) + val(j+15, 0) * val(j, 3);
    endfunction

    function automatic string tag_of(int j);
        if (!vld[j])                                  return "R5";
        if (j >= 380 && j < 430)                      return "R6";
        if (j < 10)                                   return "R3";
        if (j >= 535 && j < 550)                      return "R4";
        if (!live(j-10) || !live(j-5) || !live(j+15)) return "R8";
        return "R1";
    endfunction

    task automatic chk(string tag, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic fill_stimulus();
        for (int j = 0; j < NEL; j++) begin
            dh[j] = DW'($urandom); dx[j] = DW'($urandom);
            dy[j] = DW'($urandom); dz[j] = DW'($urandom);
            if (j < 100)       vld[j] = 1'b1;
            else if (j < 300)  vld[j] = (($urandom % 10) < 7);
            else if (j < 380)  vld[j] = 1'b0;
            else if (j < 550)  vld[j] = 1'b1;
            else               vld[j] = 1'b0;
            if (j >= 380 && j < 430) begin
                case (((j - 380) / 5) % 4)
                    0: begin dh[j] = 16'h8000; dx[j] = 16'h8000; dy[j] = 16'h8000; dz[j] = 16'h8000; end
                    1: begin dh[j] = 16'h7FFF; dx[j] = 16'h7FFF; dy[j] = 16'h7FFF; dz[j] = 16'h7FFF; end
                    2: begin dh[j] = 16'h8000; dx[j] = 16'h7FFF; dy[j] = 16'h7FFF; dz[j] = 16'h7FFF; end
                    default: begin dh[j] = 16'h7FFF; dx[j] = 16'h8000; dy[j] = 16'h8000; dz[j] = 16'h8000; end
                endcase
            end
        end
    endtask

    initial begin
        #1000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog R1 actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd7341));
        fill_stimulus();
        repeat (3) @(negedge clk);
        chk("R7", "valid in reset", longint'(out_valid), 0);
        chk("R7", "data in reset", longint'($signed(acc_out)), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R7", "valid after reset", longint'(out_valid), 0);
        chk("R7", "data after reset", longint'($signed(acc_out)), 0);

        for (int j = 0; j < NEL + LAT; j++) begin
            @(negedge clk);
            if (j >= LAT) begin
                chk("R2", "valid", longint'(out_valid), longint'(vld[j-LAT]));
                chk(tag_of(j-LAT), "sum", longint'($signed(acc_out)), model(j-LAT));
            end
            if (j < NEL) begin
                in_valid = vld[j];
                hist_in = dh[j]; mul_x = dx[j]; mul_y = dy[j]; mul_z = dz[j];
            end else begin
                in_valid = 1'b0;
                hist_in = DW'($urandom); mul_x = DW'($urandom);
                mul_y = DW'($urandom); mul_z = DW'($urandom);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule